// File: doc/BRIEF.md
# Hardware Cursor Sprite Overlay

This block sits on the pixel path of a raster display, after the main frame fetch and before the DAC. It is given the current beam coordinates and the video pixel for that position each clock. When the beam is inside the cursor window it replaces the pixel according to a 2-bit code taken from a local pattern store holding a 64x64 cursor bitmap. Otherwise the pixel passes through unchanged. Every pixel leaves the block exactly one clock after it enters, whether or not the cursor covers it.

The cursor window starts at a programmed horizontal and vertical start position. A 6-bit hot-spot preset per axis chooses the first pattern column and row drawn at that start position, which trims the leading edge of the bitmap. A size control selects the full 64x64 bitmap or its top-left 32x32 quarter. A visibility control turns the overlay off completely.

The cursor has its own two-entry colour palette. A redirect control decides where writes on the palette port go: either to the cursor colours, or out to the main palette as a strobe.

Top module: `cursor_overlay`

## Requirements
- R1: While `rst_n` is low, `pix_out` is 0 and both cursor colours are cleared to 0.
- R2: With `ctl_visible` = 0, `pix_out` equals the `pix_in` presented one clock earlier, for every beam position.
- R3: The cursor covers a beam position only if `hstart <= beam_x < hstart + DIM - hpreset` and `vstart <= beam_y < vstart + DIM - vpreset`. Outside that window `pix_out` is the previous cycle's `pix_in`.
- R4: Inside the window the pattern column is `beam_x - hstart + hpreset` and the pattern row is `beam_y - vstart + vpreset`. The code is read from pattern byte `row*16 + col/4`, bits `[2*(col%4)+1 : 2*(col%4)]`, so the leftmost pixel of a group of four sits in the low bits. `pat_addr` uses the same byte numbering.
- R5: Code 0 passes the pixel through. Code 1 outputs the bitwise inverse of all 24 pixel bits. Code 2 outputs cursor colour 0, and code 3 outputs cursor colour 1.
- R6: `ctl_big` = 1 gives DIM = 64. `ctl_big` = 0 gives DIM = 32, and only pattern rows and columns 0..31 are drawn. A preset that is at least DIM makes that axis show nothing.
- R7: A palette write (`pal_wr` = 1) with `ctl_pal_redirect` = 1 loads cursor colour `pal_sel` at the clock edge. With `ctl_pal_redirect` = 0 it raises `main_pal_wr` in the same cycle and leaves both cursor colours unchanged.
- R8: A pattern or palette write in the same cycle as a pixel that uses the written entry does not affect that pixel. The pixel uses the old value, and the new value applies from the next cycle.
- R9: Every pixel, covered or not, appears at `pix_out` exactly one clock after it is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| beam_x | input | 11 | Current beam column |
| beam_y | input | 11 | Current beam row |
| pix_in | input | 24 | Video pixel for the current beam position |
| ctl_visible | input | 1 | Cursor overlay enable |
| ctl_big | input | 1 | 1: 64x64 cursor, 0: 32x32 cursor |
| ctl_pal_redirect | input | 1 | Routes palette port writes to the cursor colours |
| hstart | input | 11 | Window start column |
| vstart | input | 11 | Window start row |
| hpreset | input | 6 | First pattern column shown |
| vpreset | input | 6 | First pattern row shown |
| pat_we | input | 1 | Pattern byte write strobe |
| pat_addr | input | 10 | Pattern byte address |
| pat_wdata | input | 8 | Pattern byte data |
| pal_wr | input | 1 | Palette port write strobe |
| pal_sel | input | 1 | Cursor colour entry selected |
| pal_wdata | input | 24 | Palette write data |
| main_pal_wr | output | 1 | Write strobe forwarded to the main palette |
| pix_out | output | 24 | Final pixel, one clock after input |

## Verification
Two things can happen in the same cycle: the display of a cursor pixel, and a write to the storage that pixel reads, either its pattern byte or its cursor colour. The bench provokes this by holding the beam on a pixel with code 2 and writing the same cycle. In one test it writes a new colour 0. In another it rewrites the pattern byte so that this pixel's code becomes 3. The pixel leaving that cycle must still show the old colour, and the same beam position in the next cycle must show the new one.

// File: rtl/cursor_ovl_pkg.sv
package cursor_ovl_pkg;

    // 2-bit pattern codes
    typedef enum logic [1:0] {
        CODE_PASS = 2'd0,
        CODE_INV  = 2'd1,
        CODE_COL0 = 2'd2,
        CODE_COL1 = 2'd3
    } cur_code_e;

    // pixels per pattern byte at 2 bits each
    localparam int PIX_PER_BYTE = 4;

endpackage

// File: rtl/cursor_axis_hit.sv
// Window compare and pattern index for one axis.
module cursor_axis_hit #(
    parameter int COORD_W = 11,
    parameter int PRE_W   = 6
) (
    input  logic [COORD_W-1:0] beam,
    input  logic [COORD_W-1:0] start,
    input  logic [PRE_W-1:0]   preset,
    input  logic               big,
    output logic               hit,
    output logic [PRE_W-1:0]   idx
);
    localparam int DIM  = 1 << PRE_W;
    localparam int HALF = DIM / 2;

    logic [COORD_W:0] diff;
    logic [PRE_W:0]   dim;
    logic [PRE_W:0]   span;
    logic             pre_ok;

    always_comb begin
        diff   = {1'b0, beam} - {1'b0, start};
        dim    = big ? (PRE_W+1)'(DIM) : (PRE_W+1)'(HALF);
        pre_ok = {1'b0, preset} < dim;
        span   = dim - {1'b0, preset};
        hit    = !diff[COORD_W] && pre_ok &&
                 (diff[COORD_W-1:0] < COORD_W'(span));
        idx    = diff[PRE_W-1:0] + preset;
    end
endmodule

// File: rtl/cursor_pat_ram.sv
// Local cursor bitmap: byte writes, combinational 2-bit code read.
module cursor_pat_ram #(
    parameter int PRE_W = 6
) (
    input  logic                clk,
    input  logic                we,
    input  logic [2*PRE_W-3:0]  waddr,
    input  logic [7:0]          wdata,
    input  logic [PRE_W-1:0]    row,
    input  logic [PRE_W-1:0]    col,
    output logic [1:0]          code
);
    localparam int DIM    = 1 << PRE_W;
    localparam int BYTES  = DIM * DIM / cursor_ovl_pkg::PIX_PER_BYTE;
    localparam int ADDR_W = $clog2(BYTES);

    logic [7:0]        mem_q [BYTES];
    logic [ADDR_W-1:0] raddr;
    logic [7:0]        rbyte;
    logic [1:0]        lane;

    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    always_comb begin
        raddr = {row, col[PRE_W-1:2]};
        lane  = col[1:0];
        rbyte = mem_q[raddr];
        code  = rbyte[{lane, 1'b0} +: 2];
    end
endmodule

// File: rtl/cursor_palette.sv
// Two-entry cursor colour palette and main-palette write routing.
module cursor_palette #(
    parameter int PIX_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             redirect,
    input  logic             wr,
    input  logic             sel,
    input  logic [PIX_W-1:0] wdata,
    output logic             main_wr,
    output logic [PIX_W-1:0] col0,
    output logic [PIX_W-1:0] col1
);
    logic [PIX_W-1:0] col_d [2];
    logic [PIX_W-1:0] col_q [2];

    always_comb begin
        col_d[0] = col_q[0];
        col_d[1] = col_q[1];
        if (wr && redirect) begin
            col_d[sel] = wdata;
        end
        main_wr = wr && !redirect;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            col_q[0] <= '0;
            col_q[1] <= '0;
        end else begin
            col_q[0] <= col_d[0];
            col_q[1] <= col_d[1];
        end
    end

    assign col0 = col_q[0];
    assign col1 = col_q[1];

    // R7: a write steered to the main palette leaves the cursor colours alone
    a_r7_main_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && !redirect) |=> ($stable(col0) && $stable(col1)));

    // R7: cursor colours move only on a redirected write
    a_r7_idle_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        !wr |=> ($stable(col0) && $stable(col1)));
endmodule

// File: rtl/cursor_overlay.sv
module cursor_overlay #(
    parameter int COORD_W = 11,
    parameter int PRE_W   = 6,
    parameter int PIX_W   = 24
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [COORD_W-1:0] beam_x,
    input  logic [COORD_W-1:0] beam_y,
    input  logic [PIX_W-1:0]   pix_in,
    input  logic               ctl_visible,
    input  logic               ctl_big,
    input  logic               ctl_pal_redirect,
    input  logic [COORD_W-1:0] hstart,
    input  logic [COORD_W-1:0] vstart,
    input  logic [PRE_W-1:0]   hpreset,
    input  logic [PRE_W-1:0]   vpreset,
    input  logic               pat_we,
    input  logic [2*PRE_W-3:0] pat_addr,
    input  logic [7:0]         pat_wdata,
    input  logic               pal_wr,
    input  logic               pal_sel,
    input  logic [PIX_W-1:0]   pal_wdata,
    output logic               main_pal_wr,
    output logic [PIX_W-1:0]   pix_out
);
    import cursor_ovl_pkg::*;

    localparam int DIM = 1 << PRE_W;

    typedef struct packed {
        logic [PIX_W-1:0] pix;
    } ovl_t;

    ovl_t ovl_d, ovl_q;

    logic             h_hit, v_hit;
    logic [PRE_W-1:0] col_idx, row_idx;
    logic [1:0]       code;
    logic [PIX_W-1:0] col0, col1;

    cursor_axis_hit #(.COORD_W(COORD_W), .PRE_W(PRE_W)) u_hx (
        .beam(beam_x), .start(hstart), .preset(hpreset), .big(ctl_big),
        .hit(h_hit), .idx(col_idx)
    );

    cursor_axis_hit #(.COORD_W(COORD_W), .PRE_W(PRE_W)) u_hy (
        .beam(beam_y), .start(vstart), .preset(vpreset), .big(ctl_big),
        .hit(v_hit), .idx(row_idx)
    );

    cursor_pat_ram #(.PRE_W(PRE_W)) u_ram (
        .clk(clk), .we(pat_we), .waddr(pat_addr), .wdata(pat_wdata),
        .row(row_idx), .col(col_idx), .code(code)
    );

    cursor_palette #(.PIX_W(PIX_W)) u_pal (
        .clk(clk), .rst_n(rst_n), .redirect(ctl_pal_redirect),
        .wr(pal_wr), .sel(pal_sel), .wdata(pal_wdata),
        .main_wr(main_pal_wr), .col0(col0), .col1(col1)
    );

    always_comb begin
        ovl_d.pix = pix_in;
        if (ctl_visible && h_hit && v_hit) begin
            unique case (cur_code_e'(code))
                CODE_PASS: ovl_d.pix = pix_in;
                CODE_INV:  ovl_d.pix = ~pix_in;
                CODE_COL0: ovl_d.pix = col0;
                CODE_COL1: ovl_d.pix = col1;
                default:   ovl_d.pix = pix_in;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ovl_q <= '0;
        end else begin
            ovl_q <= ovl_d;
        end
    end

    assign pix_out = ovl_q.pix;

    // R1: output cleared while reset is held
    a_r1_reset_out: assert property (@(posedge clk)
        !rst_n |=> (pix_out == '0));

    // R2, R9: hidden cursor gives a one-cycle pass-through
    a_r2_hidden_pass: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_visible |=> (pix_out == $past(pix_in)));

    // R3: positions outside the window pass through
    a_r3_outside_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_visible && !(h_hit && v_hit)) |=> (pix_out == $past(pix_in)));

    // R6: a covered position never indexes past the selected cursor size
    a_r6_idx_in_size: assert property (@(posedge clk) disable iff (!rst_n)
        (h_hit && v_hit) |->
        ((int'(col_idx) < (ctl_big ? DIM : DIM/2)) &&
         (int'(row_idx) < (ctl_big ? DIM : DIM/2))));
endmodule

// File: tb/sim_cursor_overlay.sv
`timescale 1ns/1ps
module sim_cursor_overlay;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [10:0] beam_x = '0, beam_y = '0, hstart = '0, vstart = '0;
    logic [23:0] pix_in = '0, pal_wdata = '0;
    logic        ctl_visible = 1'b0, ctl_big = 1'b1, ctl_pal_redirect = 1'b0;
    logic [5:0]  hpreset = '0, vpreset = '0;
    logic        pat_we = 1'b0, pal_wr = 1'b0, pal_sel = 1'b0;
    logic [9:0]  pat_addr = '0;
    logic [7:0]  pat_wdata = '0;
    logic        main_pal_wr;
    logic [23:0] pix_out;

    int total = 0;
    int bad = 0;
    bit done = 0;
    logic [23:0] c0 = 24'h112233;
    logic [23:0] c1 = 24'hA5C3E1;

    always #10 clk = ~clk;

    cursor_overlay u0 (
        .clk(clk), .rst_n(rst_n), .beam_x(beam_x), .beam_y(beam_y),
        .pix_in(pix_in), .ctl_visible(ctl_visible), .ctl_big(ctl_big),
        .ctl_pal_redirect(ctl_pal_redirect), .hstart(hstart), .vstart(vstart),
        .hpreset(hpreset), .vpreset(vpreset), .pat_we(pat_we),
        .pat_addr(pat_addr), .pat_wdata(pat_wdata), .pal_wr(pal_wr),
        .pal_sel(pal_sel), .pal_wdata(pal_wdata), .main_pal_wr(main_pal_wr),
        .pix_out(pix_out)
    );

    // kind: 0 pass, 1 invert, 2 colour 0, 3 colour 1
    typedef struct packed {
        logic [10:0] x;
        logic [10:0] y;
        logic [23:0] pix;
        logic [1:0]  kind;
    } vec_t;

    // window: hstart 100, vstart 50, hpreset 2, vpreset 3, 64x64, code=(row+col)%4
    localparam vec_t VECS[11] = '{
        '{x: 11'd100, y: 11'd50,  pix: 24'h0F0F0F, kind: 2'd1},
        '{x: 11'd99,  y: 11'd50,  pix: 24'h123456, kind: 2'd0},
        '{x: 11'd101, y: 11'd50,  pix: 24'h654321, kind: 2'd2},
        '{x: 11'd102, y: 11'd50,  pix: 24'hABCDEF, kind: 2'd3},
        '{x: 11'd103, y: 11'd50,  pix: 24'h00FF00, kind: 2'd0},
        '{x: 11'd161, y: 11'd50,  pix: 24'h777777, kind: 2'd2},
        '{x: 11'd162, y: 11'd50,  pix: 24'h818181, kind: 2'd0},
        '{x: 11'd100, y: 11'd49,  pix: 24'h3C3C3C, kind: 2'd0},
        '{x: 11'd100, y: 11'd110, pix: 24'hF00001, kind: 2'd1},
        '{x: 11'd100, y: 11'd111, pix: 24'h0000AA, kind: 2'd0},
        '{x: 11'd130, y: 11'd80,  pix: 24'h5A5A5A, kind: 2'd1}
    };

    function automatic logic [23:0] expect_pix(input logic [1:0] kind,
                                               input logic [23:0] p);
        case (kind)
            2'd1:    return ~p;
            2'd2:    return c0;
            2'd3:    return c1;
            default: return p;
        endcase
    endfunction

    task automatic check(input string req, input logic [23:0] act,
                         input logic [23:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // present one pixel and check it one clock later
    task automatic pixel(input string req, input logic [10:0] x,
                         input logic [10:0] y, input logic [23:0] p,
                         input logic [23:0] exp);
        @(negedge clk);
        beam_x = x; beam_y = y; pix_in = p;
        @(posedge clk); #1;
        check(req, pix_out, exp);
    endtask

    task automatic pal_write(input logic sel, input logic [23:0] d);
        @(negedge clk);
        ctl_pal_redirect = 1'b1; pal_wr = 1'b1; pal_sel = sel; pal_wdata = d;
        @(negedge clk);
        pal_wr = 1'b0;
    endtask

    function automatic logic [7:0] pat_byte(input int r, input int k);
        logic [7:0] b = '0;
        for (int j = 0; j < 4; j++) begin
            b[2*j +: 2] = 2'((r + 4*k + j) % 4);
        end
        return b;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        pix_in = 24'hFFFFFF;
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset pix_out", pix_out, 24'h0);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: cursor colours cleared by reset (code 2 pixel shows 0)
        for (int k = 0; k < 16; k++) begin
            @(negedge clk);
            pat_we = 1'b1; pat_addr = 10'(3*16 + k); pat_wdata = pat_byte(3, k);
        end
        @(negedge clk); pat_we = 1'b0;
        hstart = 11'd100; vstart = 11'd50; hpreset = 6'd2; vpreset = 6'd3;
        ctl_visible = 1'b1; ctl_big = 1'b1;
        pixel("R1 colour0 after reset", 11'd101, 11'd50, 24'h010101, 24'h0);

        // fill the whole pattern
        for (int r = 0; r < 64; r++) begin
            for (int k = 0; k < 16; k++) begin
                @(negedge clk);
                pat_we = 1'b1; pat_addr = 10'(r*16 + k); pat_wdata = pat_byte(r, k);
            end
        end
        @(negedge clk); pat_we = 1'b0;
        pal_write(1'b0, c0);
        pal_write(1'b1, c1);

        // R3 R4 R5 R9: table walk
        foreach (VECS[i]) begin
            pixel("R3/R4/R5 table", VECS[i].x, VECS[i].y, VECS[i].pix,
                  expect_pix(VECS[i].kind, VECS[i].pix));
        end

        // R2: hidden cursor passes pixel through
        @(negedge clk); ctl_visible = 1'b0;
        pixel("R2 hidden", 11'd101, 11'd50, 24'h246801, 24'h246801);
        @(negedge clk); ctl_visible = 1'b1;

        // R6: 32x32 mode
        @(negedge clk); ctl_big = 1'b0;
        pixel("R6 small last col", 11'd129, 11'd50, 24'h13579B, c0);
        pixel("R6 small past edge", 11'd130, 11'd50, 24'h13579B, 24'h13579B);
        @(negedge clk); hpreset = 6'd40;
        pixel("R6 preset beyond size", 11'd100, 11'd50, 24'h0A0B0C, 24'h0A0B0C);
        @(negedge clk); hpreset = 6'd2; ctl_big = 1'b1;

        // R7: write routed to main palette
        @(negedge clk);
        ctl_pal_redirect = 1'b0; pal_wr = 1'b1; pal_sel = 1'b0;
        pal_wdata = 24'hDEAD00; beam_x = 11'd101; beam_y = 11'd50;
        pix_in = 24'h000001;
        #1;
        check("R7 main_pal_wr raised", {23'h0, main_pal_wr}, 24'h1);
        @(negedge clk); pal_wr = 1'b0;
        #1;
        check("R7 main_pal_wr idle", {23'h0, main_pal_wr}, 24'h0);
        pixel("R7 cursor colour kept", 11'd101, 11'd50, 24'h000002, c0);
        // R7: redirected write
        @(negedge clk);
        ctl_pal_redirect = 1'b1; pal_wr = 1'b1; pal_sel = 1'b1;
        pal_wdata = 24'h0C0FFE;
        #1;
        check("R7 no main strobe on redirect", {23'h0, main_pal_wr}, 24'h0);
        @(negedge clk); pal_wr = 1'b0; c1 = 24'h0C0FFE;
        pixel("R7 colour1 updated", 11'd102, 11'd50, 24'h000003, c1);

        // R8: palette write colliding with a colour-0 pixel
        @(negedge clk);
        pal_wr = 1'b1; pal_sel = 1'b0; pal_wdata = 24'h445566;
        beam_x = 11'd101; beam_y = 11'd50; pix_in = 24'h000004;
        @(posedge clk); #1;
        check("R8 palette collision old", pix_out, c0);
        @(negedge clk); pal_wr = 1'b0; c0 = 24'h445566;
        @(posedge clk); #1;
        check("R8 palette collision new", pix_out, c0);

        // R8: pattern write colliding (row 3 byte 48: col 3 code 2 -> 3)
        @(negedge clk);
        pat_we = 1'b1; pat_addr = 10'd48; pat_wdata = 8'hD3;
        @(posedge clk); #1;
        check("R8 pattern collision old", pix_out, c0);
        @(negedge clk); pat_we = 1'b0;
        @(posedge clk); #1;
        check("R8 pattern collision new", pix_out, c1);

        // R1: reset mid-run clears output
        @(negedge clk); rst_n = 1'b0;
        #1;
        check("R1 async reset", pix_out, 24'h0);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule